// File: doc/BRIEF.md
# Multi-Stream Memory Channel Controller

This block sits between a pipelined datapath and one word-addressed external memory. It offers several streamed read channels and one port for random reads. Each stream channel is set up with a start address, an address step and an element count. From then on it generates its own sequence of word addresses, and the datapath does not take part. A round-robin scheduler hands the single memory port to one pending requester at a time. Only one memory transaction is in flight at any moment.

Each returned memory word is split into narrower datapath elements, lowest lane first, one element every transfer period. The elements go into a small first-word-fall-through buffer for that channel. A channel whose buffer cannot take a whole word leaves arbitration until the datapath drains it. A sticky prologue flag tells the datapath when every programmed channel has filled its buffer or finished, so that pipelined execution can begin.

The memory sequencer has five states:
- `M_IDLE` arbitrates. Going `M_IDLE`→`M_ISSUE` is a stream grant; going `M_IDLE`→`M_SETUP` is a random grant.
- `M_SETUP` counts the random-access overhead and then moves to `M_ISSUE`.
- `M_ISSUE` drives the request for one cycle and moves to `M_WAIT`.
- `M_WAIT` holds until the read data is valid. It then goes to `M_UNPACK` for a stream, or back to `M_IDLE` for a random read.
- `M_UNPACK` pushes lanes and returns to `M_IDLE` after the last lane.

Each channel has four states:
- `CH_IDLE` is the state out of reset.
- A configuration write moves the channel from any state to `CH_RELOAD`.
- `CH_RELOAD` moves to `CH_RUN` when the reload count expires.
- `CH_RUN` moves to `CH_DONE` once no elements remain and no word is in flight.
- `CH_DONE` holds until the next configuration write.

Top module: `mstream_ctrl`

## Requirements
- R1: Stream word k of a channel reads address (start + k*step) modulo 2^ADDR_W, starting at k = 0. One memory word is fetched per GRAN = MEM_W/ELEM_W elements.
- R2: Lane j of a memory word is bits [j*ELEM_W +: ELEM_W], and lanes are delivered from j = 0 upward. When the count is not a multiple of GRAN, the last word supplies only the remaining elements, so exactly the programmed count reaches the buffer.
- R3: After a configuration write, the channel makes no memory request for RELOAD_CYC cycles. With an idle block and a datapath that pops at once, the first element becomes visible 15 cycles after the write cycle (defaults: RELOAD_CYC=3, memory latency 7, XFER_CYC=2).
- R4: A random read pays RAND_OVH setup cycles before its request. From an idle block, rand_valid appears 12 cycles after rand_req is raised, and rand_rdata is the memory word at rand_addr. The requester lowers rand_req after rand_valid.
- R5: mem_req lasts exactly one cycle, and no new request is issued while a read is outstanding.
- R6: Consecutive elements of one word enter the buffer XFER_CYC cycles apart.
- R7: Grants rotate round-robin across the stream channels and the random port, starting from the index after the last grant. With two streams always pending, their memory requests alternate, and channel 0 is served first after reset.
- R8: ch_done[c] rises once all programmed elements of channel c have been written into its buffer, and stays high until the next write to that channel. A write clears it. A count of 0 completes after the reload with no memory access.
- R9: A channel requests memory only while its buffer has room for GRAN elements. With no pops, a full buffer stops all of its requests, and no element is lost or reordered.
- R10: prologue_done goes high once every programmed channel has either a full buffer or ch_done set. It stays high until any configuration write clears it.
- R11: After reset, every channel is idle and ch_done, dp_valid, mem_req, rand_valid and prologue_done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel to be configured |
| cfg_base | input | ADDR_W | Start word address |
| cfg_stride | input | ADDR_W | Address step per word |
| cfg_count | input | CNT_W | Number of elements |
| ch_done | output | NCH | Per-channel completion flag |
| prologue_done | output | 1 | All programmed buffers primed |
| dp_valid | output | NCH | Buffer head holds an element |
| dp_pop | input | NCH | Datapath consumes the head element |
| dp_data | output | NCH*ELEM_W | Head elements, channel c at [c*ELEM_W +: ELEM_W] |
| rand_req | input | 1 | Random read request (level) |
| rand_addr | input | ADDR_W | Random read address |
| rand_valid | output | 1 | Random read data valid (pulse) |
| rand_rdata | output | MEM_W | Random read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | MEM_W | Memory read data |

## Verification
The bench uses the defaults: two channels, 32-bit words split into four 8-bit lanes, and 8-deep buffers. The buffer then holds exactly two words. A five-element count ends on a partial word, and a backlog of twenty elements fills the buffer and stalls the channel. With three requesters, the round-robin order and the random port's extra setup can be seen on the memory request stream. A fixed memory latency of 7 makes the cycle counts of R3 and R4 exact.

// File: rtl/mstream_pkg.sv
package mstream_pkg;
    typedef enum logic [1:0] {CH_IDLE, CH_RELOAD, CH_RUN, CH_DONE} ch_state_e;
    typedef enum logic [2:0] {M_IDLE, M_SETUP, M_ISSUE, M_WAIT, M_UNPACK} mem_state_e;
endpackage

// File: rtl/mstream_agen.sv
module mstream_agen
    import mstream_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 8,
    parameter int GRAN       = 4,
    parameter int RELOAD_CYC = 3,
    parameter int LANE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              space_ok,
    input  logic              take,
    input  logic              fin,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic [LANE_W-1:0] take_n,
    output logic              done,
    output logic              active
);
    localparam int RW = $clog2(RELOAD_CYC + 1);

    ch_state_e         state, nstate;
    logic [RW-1:0]     rcnt;
    logic [ADDR_W-1:0] step_q;
    logic [CNT_W-1:0]  left;
    logic              inflight;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            CH_IDLE:   nstate = CH_IDLE;
            CH_RELOAD: if (rcnt == '0) nstate = CH_RUN;
            CH_RUN:    if (left == '0 && !inflight) nstate = CH_DONE;
            CH_DONE:   nstate = CH_DONE;
            default:   nstate = CH_IDLE;
        endcase
        if (cfg_we) nstate = CH_RELOAD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt     <= '0;
            addr     <= '0;
            step_q   <= '0;
            left     <= '0;
            inflight <= 1'b0;
        end else if (cfg_we) begin
            rcnt     <= RW'(RELOAD_CYC - 1);
            addr     <= cfg_base;
            step_q   <= cfg_stride;
            left     <= cfg_count;
            inflight <= 1'b0;
        end else begin
            if (state == CH_RELOAD && rcnt != '0) rcnt <= rcnt - 1'b1;
            if (take) begin
                addr     <= addr + step_q;
                left     <= left - CNT_W'(take_n);
                inflight <= 1'b1;
            end else if (fin) begin
                inflight <= 1'b0;
            end
        end
    end

    always_comb begin
        req    = (state == CH_RUN) && (left != '0) && !inflight && space_ok;
        take_n = (left < CNT_W'(GRAN)) ? LANE_W'(left) : LANE_W'(GRAN);
        done   = (state == CH_DONE);
        active = (state != CH_IDLE);
    end

    // checker state: cycles since the last configuration write, saturating
    logic [RW-1:0] since_cfg;
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_we)                 since_cfg <= '0;
        else if (since_cfg < RW'(RELOAD_CYC)) since_cfg <= since_cfg + 1'b1;
    end

    p_reload_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> since_cfg == RW'(RELOAD_CYC));
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_we) |=> done);
    p_take_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> req);
endmodule

// File: rtl/mstream_buf.sv
module mstream_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (push) store[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    assign rdata = store[rp];
    assign empty = (level == '0);
    assign full  = (level == LVL_W'(DEPTH));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/mstream_rr.sv
module mstream_rr #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);
    logic [IW-1:0] last;

    always_comb begin
        int cand;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last) + k) % N;
            if (!gnt_any && req[cand]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   last <= IW'(N - 1);
        else if (advance && gnt_any)  last <= gnt_idx;
    end

    // fairness checker: grants given to others while a requester waits
    for (genvar r = 0; r < N; r++) begin : g_fair
        logic [IW:0] waited;
        always_ff @(posedge clk) begin
            if (!rst_n || !req[r] || (advance && gnt_any && gnt_idx == IW'(r)))
                waited <= '0;
            else if (advance && gnt_any && waited != '1)
                waited <= waited + 1'b1;
        end
        p_rr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            waited < (IW+1)'(N));
    end
endmodule

// File: rtl/mstream_ctrl.sv
module mstream_ctrl
    import mstream_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int ADDR_W     = 16,
    parameter int MEM_W      = 32,
    parameter int ELEM_W     = 8,
    parameter int CNT_W      = 8,
    parameter int BUF_DEPTH  = 8,
    parameter int RELOAD_CYC = 3,
    parameter int RAND_OVH   = 3,
    parameter int XFER_CYC   = 2,
    parameter int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CH_W-1:0]       cfg_ch,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [ADDR_W-1:0]     cfg_stride,
    input  logic [CNT_W-1:0]      cfg_count,
    output logic [NCH-1:0]        ch_done,
    output logic                  prologue_done,
    output logic [NCH-1:0]        dp_valid,
    input  logic [NCH-1:0]        dp_pop,
    output logic [NCH*ELEM_W-1:0] dp_data,
    input  logic                  rand_req,
    input  logic [ADDR_W-1:0]     rand_addr,
    output logic                  rand_valid,
    output logic [MEM_W-1:0]      rand_rdata,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_rvalid,
    input  logic [MEM_W-1:0]      mem_rdata
);
    localparam int GRAN   = MEM_W / ELEM_W;
    localparam int NREQ   = NCH + 1;
    localparam int IW     = $clog2(NREQ);
    localparam int LANE_W = $clog2(GRAN + 1);
    localparam int LVL_W  = $clog2(BUF_DEPTH + 1);
    localparam int OMAX   = (RAND_OVH > XFER_CYC) ? RAND_OVH : XFER_CYC;
    localparam int OW     = $clog2(OMAX + 1);

    mem_state_e        mstate, mnext;
    logic [IW-1:0]     gidx_q;
    logic              is_rand_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANE_W-1:0] lanes_q, lane_q;
    logic [OW-1:0]     ocnt;
    logic [MEM_W-1:0]  word_q;

    logic [NCH-1:0]    ch_req, ch_take, ch_push, ch_fin, ch_active, ch_full, space_ok;
    logic [ADDR_W-1:0] ch_addr   [NCH];
    logic [LANE_W-1:0] ch_take_n [NCH];
    logic [IW-1:0]     gnt_idx;
    logic              gnt_any;
    logic [ELEM_W-1:0] elem;
    logic              last_lane, arb_slot;

    assign arb_slot  = (mstate == M_IDLE);
    assign elem      = word_q[lane_q*ELEM_W +: ELEM_W];
    assign last_lane = (lane_q == lanes_q - 1'b1);

    mstream_rr #(.N(NREQ), .IW(IW)) u_rr (
        .clk(clk), .rst_n(rst_n), .req({rand_req, ch_req}),
        .advance(arb_slot), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [LVL_W-1:0] lvl;
        logic             empty;

        assign ch_take[c]  = arb_slot && gnt_any && (gnt_idx == IW'(c));
        assign ch_push[c]  = (mstate == M_UNPACK) && (ocnt == '0) && (gidx_q == IW'(c));
        assign ch_fin[c]   = ch_push[c] && last_lane;
        assign space_ok[c] = (LVL_W'(BUF_DEPTH) - lvl) >= LVL_W'(GRAN);
        assign dp_valid[c] = !empty;

        mstream_agen #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W), .GRAN(GRAN),
            .RELOAD_CYC(RELOAD_CYC), .LANE_W(LANE_W)
        ) u_agen (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(cfg_we && (cfg_ch == CH_W'(c))),
            .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_count(cfg_count),
            .space_ok(space_ok[c]), .take(ch_take[c]), .fin(ch_fin[c]),
            .req(ch_req[c]), .addr(ch_addr[c]), .take_n(ch_take_n[c]),
            .done(ch_done[c]), .active(ch_active[c])
        );

        mstream_buf #(.W(ELEM_W), .DEPTH(BUF_DEPTH), .LVL_W(LVL_W)) u_buf (
            .clk(clk), .rst_n(rst_n), .push(ch_push[c]), .wdata(elem),
            .pop(dp_pop[c]), .rdata(dp_data[c*ELEM_W +: ELEM_W]),
            .empty(empty), .full(ch_full[c]), .level(lvl)
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mstate <= M_IDLE;
        else        mstate <= mnext;
    end

    // next state
    always_comb begin
        mnext = mstate;
        unique case (mstate)
            M_IDLE:   if (gnt_any) mnext = (gnt_idx == IW'(NCH)) ? M_SETUP : M_ISSUE;
            M_SETUP:  if (ocnt == '0) mnext = M_ISSUE;
            M_ISSUE:  mnext = M_WAIT;
            M_WAIT:   if (mem_rvalid) mnext = is_rand_q ? M_IDLE : M_UNPACK;
            M_UNPACK: if (ocnt == '0 && last_lane) mnext = M_IDLE;
            default:  mnext = M_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        mem_req  = (mstate == M_ISSUE);
        mem_addr = addr_q;
    end

    // sequencer working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gidx_q     <= '0;
            is_rand_q  <= 1'b0;
            addr_q     <= '0;
            lanes_q    <= '0;
            lane_q     <= '0;
            ocnt       <= '0;
            word_q     <= '0;
            rand_valid <= 1'b0;
            rand_rdata <= '0;
        end else begin
            rand_valid <= 1'b0;
            unique case (mstate)
                M_IDLE: if (gnt_any) begin
                    gidx_q    <= gnt_idx;
                    is_rand_q <= (gnt_idx == IW'(NCH));
                    addr_q    <= (gnt_idx == IW'(NCH)) ? rand_addr : ch_addr[gnt_idx];
                    lanes_q   <= (gnt_idx == IW'(NCH)) ? '0 : ch_take_n[gnt_idx];
                    ocnt      <= OW'(RAND_OVH - 1);
                end
                M_SETUP: if (ocnt != '0) ocnt <= ocnt - 1'b1;
                M_ISSUE: ;
                M_WAIT: if (mem_rvalid) begin
                    word_q <= mem_rdata;
                    lane_q <= '0;
                    ocnt   <= OW'(XFER_CYC - 1);
                    if (is_rand_q) begin
                        rand_valid <= 1'b1;
                        rand_rdata <= mem_rdata;
                    end
                end
                M_UNPACK: if (ocnt == '0) begin
                    ocnt   <= OW'(XFER_CYC - 1);
                    lane_q <= lane_q + 1'b1;
                end else begin
                    ocnt <= ocnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // prologue tracking
    logic [NCH-1:0] primed;
    assign primed = ~ch_active | ch_full | ch_done;
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_we)                      prologue_done <= 1'b0;
        else if ((&primed) && (|ch_active))        prologue_done <= 1'b1;
    end

    // checker: outstanding read
    logic pend;
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= 1'b0;
        else if (mem_req)    pend <= 1'b1;
        else if (mem_rvalid) pend <= 1'b0;
    end

    p_single_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend);
    p_onehot_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_push));
    if (XFER_CYC >= 2) begin : g_gap
        p_push_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (|ch_push) |=> !(|ch_push));
    end
    p_prologue_needs_work_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prologue_done) |-> $past(|ch_active));
endmodule

// File: tb/mstream_ctrl_test.sv
module mstream_ctrl_test;
    localparam int NCH = 2, AW = 16, MW = 32, EW = 8, GRAN = MW / EW;
    localparam int MEM_LAT = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [0:0] cfg_ch = '0;
    logic [AW-1:0] cfg_base = '0, cfg_stride = '0, rand_addr = '0;
    logic [7:0] cfg_count = '0;
    logic [NCH-1:0] ch_done, dp_valid;
    logic [NCH-1:0] dp_pop = '0;
    logic [NCH*EW-1:0] dp_data;
    logic prologue_done, rand_req = 1'b0, rand_valid, mem_req, mem_rvalid;
    logic [MW-1:0] rand_rdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    always #2.5 clk = ~clk;

    mstream_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_count(cfg_count),
        .ch_done(ch_done), .prologue_done(prologue_done), .dp_valid(dp_valid),
        .dp_pop(dp_pop), .dp_data(dp_data), .rand_req(rand_req),
        .rand_addr(rand_addr), .rand_valid(rand_valid), .rand_rdata(rand_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [MW-1:0] mem_word(input logic [AW-1:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ {16'hC3D2, a};
    endfunction

    function automatic logic [EW-1:0] exp_elem(input logic [AW-1:0] b, s, input int k);
        logic [AW-1:0] wa;
        logic [MW-1:0] w;
        wa = b + AW'(k / GRAN) * s;
        w  = mem_word(wa);
        return w[(k % GRAN)*EW +: EW];
    endfunction

    // fixed-latency memory model
    logic [MEM_LAT-1:0] vsr = '0;
    logic [AW-1:0] lat_addr = '0;
    always @(posedge clk) begin
        vsr <= {vsr[MEM_LAT-2:0], mem_req};
        if (mem_req) lat_addr <= mem_addr;
    end
    assign mem_rvalid = vsr[MEM_LAT-1];
    assign mem_rdata  = mem_word(lat_addr);

    int vectors = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // stream scoreboard and consumer
    logic [AW-1:0] cb [NCH];
    logic [AW-1:0] cs [NCH];
    int cc [NCH];
    int ek [NCH];
    int pop_mode = 0;

    initial begin
        for (int c = 0; c < NCH; c++) begin cb[c] = '0; cs[c] = '0; cc[c] = 0; ek[c] = 0; end
        forever begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                dp_pop[c] = 1'b0;
                if (rst_n && dp_valid[c] &&
                    (pop_mode == 1 || (pop_mode == 2 && ($urandom % 10) < 6))) begin
                    chk(ek[c] < cc[c], "R2 extra element", ek[c], cc[c]);
                    chk(dp_data[c*EW +: EW] == exp_elem(cb[c], cs[c], ek[c]),
                        "R1/R2 element value", dp_data[c*EW +: EW], exp_elem(cb[c], cs[c], ek[c]));
                    ek[c]++;
                    dp_pop[c] = 1'b1;
                end
            end
        end
    end

    // memory request log
    logic [AW-1:0] alog [256];
    int txn = 0;
    initial forever begin
        @(negedge clk);
        if (mem_req) begin
            alog[txn % 256] = mem_addr;
            txn++;
        end
    end

    task automatic prog(input int c, input logic [AW-1:0] b, input logic [AW-1:0] s, input int n);
        cb[c] = b; cs[c] = s; cc[c] = n; ek[c] = 0;
        cfg_we = 1'b1; cfg_ch = 1'(c); cfg_base = b; cfg_stride = s; cfg_count = 8'(n);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drain(input logic [NCH-1:0] mask, input string r);
        int t = 0;
        bit ok;
        do begin
            @(negedge clk);
            t++;
            ok = 1;
            for (int c = 0; c < NCH; c++)
                if (mask[c] && !(ch_done[c] && ek[c] == cc[c])) ok = 0;
        end while (!ok && t < 20000);
        chk(ok, r, t, 0);
        for (int c = 0; c < NCH; c++)
            if (mask[c]) chk(ek[c] == cc[c], r, ek[c], cc[c]);
    endtask

    task automatic rand_read(input logic [AW-1:0] a, output int lat);
        lat = 0;
        rand_addr = a;
        rand_req = 1'b1;
        do begin @(negedge clk); lat++; end while (!rand_valid && lat < 2000);
        rand_req = 1'b0;
        chk(rand_rdata == mem_word(a), "R4 random data", rand_rdata, mem_word(a));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int n, g, base, lat;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(ch_done == '0, "R11 ch_done", ch_done, 0);
        chk(dp_valid == '0, "R11 dp_valid", dp_valid, 0);
        chk(!mem_req && !rand_valid, "R11 mem_req/rand_valid", {mem_req, rand_valid}, 0);
        chk(!prologue_done, "R11 prologue_done", prologue_done, 0);

        // R3 reload latency, R6 lane spacing, R1/R2 partial last word
        pop_mode = 1;
        base = txn;
        prog(0, 16'h0200, 16'd5, 5);
        n = 1;
        while (!dp_valid[0] && n < 100) begin @(negedge clk); n++; end
        chk(n == 1 + 3 + 1 + 1 + (MEM_LAT - 1) + 1 + 2, "R3 first element latency", n, 15);
        g = 0;
        do begin @(negedge clk); g++; end while (!dp_valid[0] && g < 50);
        chk(g == 2, "R6 element spacing", g, 2);
        drain(2'b01, "R2 partial word drain");
        chk(txn - base == 2, "R1 word count", txn - base, 2);
        chk(alog[base % 256] == 16'h0200, "R1 first address", alog[base % 256], 16'h0200);
        chk(alog[(base + 1) % 256] == 16'h0205, "R1 second address", alog[(base + 1) % 256], 16'h0205);

        // R4 random read from idle
        rand_read(16'h1234, lat);
        chk(lat == 1 + 3 + 1 + MEM_LAT, "R4 random latency", lat, 12);

        // R7 round-robin alternation
        base = txn;
        prog(0, 16'h0100, 16'd1, 16);
        prog(1, 16'h4000, 16'd3, 16);
        drain(2'b11, "R7 drain");
        chk(txn - base == 8, "R7 request count", txn - base, 8);
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] ea;
            ea = (i % 2 == 0) ? AW'(16'h0100 + i / 2) : AW'(16'h4000 + 3 * (i / 2));
            chk(alog[(base + i) % 256] == ea, "R7 alternation", alog[(base + i) % 256], ea);
        end

        // R8 count zero completes without memory traffic, cleared by write
        base = txn;
        prog(1, 16'h0000, 16'd1, 0);
        chk(ch_done[1] == 1'b0, "R8 done cleared by write", ch_done[1], 0);
        repeat (6) @(negedge clk);
        chk(ch_done[1] == 1'b1, "R8 zero count done", ch_done[1], 1);
        chk(txn == base, "R8 zero count no access", txn - base, 0);

        // R9 back-pressure and R10 prologue
        pop_mode = 0;
        prog(0, 16'h0300, 16'd2, 20);
        chk(!prologue_done, "R10 cleared by write", prologue_done, 0);
        prog(1, 16'h0500, 16'd1, 3);
        repeat (150) @(negedge clk);
        chk(prologue_done, "R10 prologue set", prologue_done, 1);
        chk(!ch_done[0], "R9 stalled channel not done", ch_done[0], 0);
        chk(ch_done[1], "R8 short channel done", ch_done[1], 1);
        base = txn;
        repeat (50) @(negedge clk);
        chk(txn == base, "R9 no requests while full", txn - base, 0);
        pop_mode = 1;
        drain(2'b11, "R9 drain after stall");

        // constrained random rounds with interleaved random reads
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < NCH; c++)
                prog(c, AW'($urandom), AW'(1 + $urandom % 4), int'($urandom % 25));
            pop_mode = 2;
            for (int q = 0; q < 2; q++) begin
                repeat ($urandom % 20) @(negedge clk);
                rand_read(AW'($urandom), lat);
            end
            drain(2'b11, "R1/R8 random round");
            pop_mode = 1;
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule